// File: doc/BRIEF.md
# Per-Core Local Interrupt Unit

This block keeps the private interrupt sources of every processor core in a cluster: a timer tick, a performance-counter overflow, a debug-channel event and two software interrupts. Every core owns a bank of state: an enable mask, a pending register, one routing entry per source and a control register. From the routing entries and that state, the block drives an interrupt request on one of the core's interrupt lines and gives a matching vector number.

Software reaches the banks through one write port and one read port. Each access is tagged with the number of the issuing core, and a plain access lands in that core's own bank. A core can also program a different core. It first stores a target core number in its own select register. After that, a small set of mirror addresses is redirected to the target core's bank. The control register reports which sources may be routed to a pin, and it holds a vectored-mode enable. In vectored mode every source is treated as routable.

Top module: `lirq_unit`

## Requirements
- R1: After reset, every core's mask, pending bits, routing entries, vectored-mode bit and other-core select read as zero, and all interrupt lines and vectors are zero.
- R2: Source bit order is timer=0, perf=1, debug=2, soft0=3, soft1=4. A write to SETMASK (address 2) ORs data[4:0] into the mask (read at address 1). A write to CLRMASK (address 3) clears the mask bits where the data is one, so writing 0xFF disables every source.
- R3: A strobe on evtStrobe[3*core+k] (k = 0 timer, 1 perf, 2 debug) sets pending bit k. A write to SWRAISE (address 5) sets only pending bits 3 and 4 from the data. A write to PEND (address 4, also read there) clears pending bits where the data is one. A strobe in the same cycle as a clear of that bit leaves the bit set.
- R4: A routing entry at address 16+source holds an enable in bit 7 and a pin number in bits 2:0. Other written bits read back as zero. A source driving pin P sets irqLines bit P+2 of its core. irqVec gives the lowest driven pin plus one, or 0 when no pin is driven.
- R5: A source drives its pin only when its pending bit, its mask bit and its routing enable are all set and the source is routable.
- R6: Control (address 0) reads bit 0 as the vectored-mode enable, which is writable. Bits 4:1 read as the routable flags for timer, perf, debug and software. The default capability is 4'b0101. When vectored mode is on, all four flags read one and all sources are routable.
- R7: Local accesses use the bank of the issuing core only. Other cores' banks are unchanged.
- R8: Each issuing core has its own select register (address 6). Writes to OSETMASK (7), OCLRMASK (8) and OMAP (24+source) act on the selected core's bank. Reads of OMASK (9) and OMAP return that bank.
- R9: A select write whose value is not a present core number leaves the select unchanged.
- R10: A source routed to a pin number at or above the pin count drives no line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| wrCore | input | 4 | Issuing core of the write |
| wrAddr | input | 5 | Write register address |
| wrData | input | 8 | Write data |
| rdCore | input | 4 | Issuing core of the read |
| rdAddr | input | 5 | Read register address |
| rdData | output | 8 | Read data (combinational) |
| evtStrobe | input | 9 | Hardware event strobes, three per core |
| irqLines | output | 24 | Interrupt lines, eight per core |
| irqVec | output | 9 | Vector number, three bits per core |

## Verification
The pending register has two sources of change that can fall in the same clock: a hardware event strobe that sets a bit, and a write-one-to-clear that removes it. The bench raises the perf strobe in the exact cycle that the clear write is presented for that bit. It then reads the pending register back and expects the bit to remain set, while the other cleared bits go to zero. A lost event would show up as a cleared bit.

// File: rtl/lirq_pkg.sv
package lirq_pkg;
  localparam int NUM_SRC = 5;
  localparam int HW_SRC = 3;
  localparam int NUM_GRP = 4;
  localparam int DATA_W = 8;
  localparam int CORE_W = 4;
  localparam int ADDR_W = 5;
  localparam int PIN_W = 3;
  localparam int MAP_EN_BIT = 7;

  localparam logic [ADDR_W-1:0] A_CTRL     = 5'd0;
  localparam logic [ADDR_W-1:0] A_MASK     = 5'd1;
  localparam logic [ADDR_W-1:0] A_SETMASK  = 5'd2;
  localparam logic [ADDR_W-1:0] A_CLRMASK  = 5'd3;
  localparam logic [ADDR_W-1:0] A_PEND     = 5'd4;
  localparam logic [ADDR_W-1:0] A_SWRAISE  = 5'd5;
  localparam logic [ADDR_W-1:0] A_OSEL     = 5'd6;
  localparam logic [ADDR_W-1:0] A_OSETMASK = 5'd7;
  localparam logic [ADDR_W-1:0] A_OCLRMASK = 5'd8;
  localparam logic [ADDR_W-1:0] A_OMASK    = 5'd9;
  localparam logic [1:0] MAP_PAGE  = 2'b10;
  localparam logic [1:0] OMAP_PAGE = 2'b11;

  localparam logic [NUM_SRC-1:0] SW_BITS = 5'b11000;

  typedef struct packed {
    logic setMask;
    logic clrMask;
    logic clrPend;
    logic raiseSw;
    logic mapWr;
    logic ctrlWr;
    logic [CORE_W-1:0] bank;
    logic [PIN_W-1:0] mapIdx;
    logic [DATA_W-1:0] data;
  } lirq_strobe_t;
endpackage

// File: rtl/lirq_ctrl.sv
module lirq_ctrl
  import lirq_pkg::*;
#(
  parameter int NUM_CORES = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [CORE_W-1:0] wrCore,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output lirq_strobe_t st,
  output logic [NUM_CORES*CORE_W-1:0] otherSelFlat
);
  logic [CORE_W-1:0] selQ [NUM_CORES];
  logic issuerOk, isMap, isOMap, isOther, selValid;
  logic [CORE_W-1:0] issuerSel;

  assign issuerOk = wrEn && (wrCore < CORE_W'(NUM_CORES));
  assign selValid = wrData < DATA_W'(NUM_CORES);

  always_comb begin
    isMap = (wrAddr[4:3] == MAP_PAGE) && (wrAddr[2:0] < PIN_W'(NUM_SRC));
    isOMap = (wrAddr[4:3] == OMAP_PAGE) && (wrAddr[2:0] < PIN_W'(NUM_SRC));
    isOther = (wrAddr == A_OSETMASK) || (wrAddr == A_OCLRMASK) || isOMap;
    issuerSel = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (wrCore == CORE_W'(c)) issuerSel = selQ[c];
    end
    st = '0;
    st.bank = isOther ? issuerSel : wrCore;
    st.data = wrData;
    st.mapIdx = wrAddr[2:0];
    if (issuerOk) begin
      case (wrAddr)
        A_SETMASK, A_OSETMASK: st.setMask = 1'b1;
        A_CLRMASK, A_OCLRMASK: st.clrMask = 1'b1;
        A_PEND:                st.clrPend = 1'b1;
        A_SWRAISE:             st.raiseSw = 1'b1;
        A_CTRL:                st.ctrlWr = 1'b1;
        default:               st.mapWr = isMap || isOMap;
      endcase
    end
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_sel
    always_ff @(posedge clk) begin
      if (!rstN) selQ[c] <= '0;
      else if (issuerOk && wrCore == CORE_W'(c) && wrAddr == A_OSEL && selValid)
        selQ[c] <= wrData[CORE_W-1:0];
    end
    assign otherSelFlat[c*CORE_W +: CORE_W] = selQ[c];

    assert_sel_store_R8: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrCore == CORE_W'(c) && wrAddr == A_OSEL && selValid)
      |=> (selQ[c] == $past(wrData[CORE_W-1:0])));
    assert_sel_reject_R9: assert property (@(posedge clk) disable iff (!rstN)
      (wrEn && wrAddr == A_OSEL && !selValid) |=> $stable(selQ[c]));
  end

  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.setMask, st.clrMask, st.clrPend, st.raiseSw, st.mapWr, st.ctrlWr}));
endmodule

// File: rtl/lirq_datapath.sv
module lirq_datapath
  import lirq_pkg::*;
#(
  parameter int NUM_CORES = 3,
  parameter int NUM_PINS = 6,
  parameter logic [NUM_GRP-1:0] ROUTE_CAPS = 4'b0101,
  localparam int LINE_W = NUM_PINS + 2,
  localparam int VEC_W = $clog2(NUM_PINS + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  lirq_strobe_t st,
  input  logic [NUM_CORES*HW_SRC-1:0] evtStrobe,
  input  logic [NUM_CORES*CORE_W-1:0] otherSelFlat,
  input  logic [CORE_W-1:0] rdCore,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CORES*LINE_W-1:0] irqLines,
  output logic [NUM_CORES*VEC_W-1:0] irqVec
);
  logic [NUM_SRC-1:0] maskQ [NUM_CORES];
  logic [NUM_SRC-1:0] pendQ [NUM_CORES];
  logic [NUM_SRC-1:0] mapEnQ [NUM_CORES];
  logic [PIN_W-1:0] mapPinQ [NUM_CORES][NUM_SRC];
  logic eicQ [NUM_CORES];
  logic [NUM_GRP-1:0] flags [NUM_CORES];
  logic unusedDataBits;

  assign unusedDataBits = ^st.data[MAP_EN_BIT-1:NUM_SRC];

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    logic hit;
    logic [NUM_SRC-1:0] pendNext, srcRoute, live;
    logic [NUM_PINS-1:0] pinHit;
    logic [VEC_W-1:0] vec;

    assign hit = (st.bank == CORE_W'(c));

    always_comb begin
      pendNext = pendQ[c];
      if (hit && st.clrPend) pendNext = pendNext & ~st.data[NUM_SRC-1:0];
      if (hit && st.raiseSw) pendNext = pendNext | (st.data[NUM_SRC-1:0] & SW_BITS);
      pendNext[HW_SRC-1:0] = pendNext[HW_SRC-1:0] | evtStrobe[c*HW_SRC +: HW_SRC];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskQ[c] <= '0;
        pendQ[c] <= '0;
        mapEnQ[c] <= '0;
        eicQ[c] <= 1'b0;
        for (int s = 0; s < NUM_SRC; s++) mapPinQ[c][s] <= '0;
      end else begin
        pendQ[c] <= pendNext;
        if (hit && st.setMask) maskQ[c] <= maskQ[c] | st.data[NUM_SRC-1:0];
        if (hit && st.clrMask) maskQ[c] <= maskQ[c] & ~st.data[NUM_SRC-1:0];
        if (hit && st.ctrlWr) eicQ[c] <= st.data[0];
        for (int s = 0; s < NUM_SRC; s++) begin
          if (hit && st.mapWr && st.mapIdx == PIN_W'(s)) begin
            mapEnQ[c][s] <= st.data[MAP_EN_BIT];
            mapPinQ[c][s] <= st.data[PIN_W-1:0];
          end
        end
      end
    end

    assign flags[c] = ROUTE_CAPS | {NUM_GRP{eicQ[c]}};
    assign srcRoute = {flags[c][3], flags[c][3], flags[c][2], flags[c][1], flags[c][0]};
    assign live = pendQ[c] & maskQ[c] & srcRoute & mapEnQ[c];

    always_comb begin
      pinHit = '0;
      for (int p = 0; p < NUM_PINS; p++)
        for (int s = 0; s < NUM_SRC; s++)
          if (live[s] && mapPinQ[c][s] == PIN_W'(p)) pinHit[p] = 1'b1;
      vec = '0;
      for (int p = NUM_PINS - 1; p >= 0; p--)
        if (pinHit[p]) vec = VEC_W'(p + 1);
    end

    assign irqLines[c*LINE_W +: LINE_W] = {pinHit, 2'b00};
    assign irqVec[c*VEC_W +: VEC_W] = vec;

    for (genvar k = 0; k < HW_SRC; k++) begin : g_evt
      assert_evt_latch_R3: assert property (@(posedge clk) disable iff (!rstN)
        evtStrobe[c*HW_SRC+k] |=> pendQ[c][k]);
    end
    assert_clr_all_R2: assert property (@(posedge clk) disable iff (!rstN)
      (hit && st.clrMask && (&st.data[NUM_SRC-1:0])) |=> (maskQ[c] == '0));
    assert_vec_match_R4: assert property (@(posedge clk) disable iff (!rstN)
      ((|irqLines[c*LINE_W +: LINE_W]) == (irqVec[c*VEC_W +: VEC_W] != '0)));
    assert_no_unmasked_R5: assert property (@(posedge clk) disable iff (!rstN)
      (maskQ[c] == '0) |-> (irqLines[c*LINE_W +: LINE_W] == '0));
  end

  always_comb begin
    logic [CORE_W-1:0] oth;
    logic [NUM_SRC-1:0] lMask, lPend, oMask;
    logic [NUM_GRP-1:0] lFlags;
    logic lEic, lEn, oEn;
    logic [PIN_W-1:0] lPin, oPin;
    oth = '0;
    for (int c = 0; c < NUM_CORES; c++)
      if (rdCore == CORE_W'(c)) oth = otherSelFlat[c*CORE_W +: CORE_W];
    lMask = '0; lPend = '0; oMask = '0; lFlags = '0; lEic = 1'b0;
    lEn = 1'b0; oEn = 1'b0; lPin = '0; oPin = '0;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (rdCore == CORE_W'(c)) begin
        lMask = maskQ[c]; lPend = pendQ[c]; lFlags = flags[c]; lEic = eicQ[c];
        for (int s = 0; s < NUM_SRC; s++)
          if (rdAddr[2:0] == PIN_W'(s)) begin lEn = mapEnQ[c][s]; lPin = mapPinQ[c][s]; end
      end
      if (oth == CORE_W'(c)) begin
        oMask = maskQ[c];
        for (int s = 0; s < NUM_SRC; s++)
          if (rdAddr[2:0] == PIN_W'(s)) begin oEn = mapEnQ[c][s]; oPin = mapPinQ[c][s]; end
      end
    end
    rdData = '0;
    case (rdAddr)
      A_CTRL:  rdData = DATA_W'({lFlags, lEic});
      A_MASK:  rdData = DATA_W'(lMask);
      A_PEND:  rdData = DATA_W'(lPend);
      A_OSEL:  rdData = DATA_W'(oth);
      A_OMASK: rdData = DATA_W'(oMask);
      default: begin
        if (rdAddr[4:3] == MAP_PAGE)
          rdData = {lEn, {(DATA_W-1-PIN_W){1'b0}}, lPin};
        else if (rdAddr[4:3] == OMAP_PAGE)
          rdData = {oEn, {(DATA_W-1-PIN_W){1'b0}}, oPin};
      end
    endcase
  end
endmodule

// File: rtl/lirq_unit.sv
module lirq_unit
  import lirq_pkg::*;
#(
  parameter int NUM_CORES = 3,
  parameter int NUM_PINS = 6,
  parameter logic [NUM_GRP-1:0] ROUTE_CAPS = 4'b0101,
  localparam int LINE_W = NUM_PINS + 2,
  localparam int VEC_W = $clog2(NUM_PINS + 1)
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic [CORE_W-1:0] wrCore,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [CORE_W-1:0] rdCore,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic [NUM_CORES*HW_SRC-1:0] evtStrobe,
  output logic [NUM_CORES*LINE_W-1:0] irqLines,
  output logic [NUM_CORES*VEC_W-1:0] irqVec
);
  lirq_strobe_t st;
  logic [NUM_CORES*CORE_W-1:0] otherSelFlat;

  lirq_ctrl #(.NUM_CORES(NUM_CORES)) ctrl_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrCore(wrCore), .wrAddr(wrAddr),
    .wrData(wrData), .st(st), .otherSelFlat(otherSelFlat)
  );

  lirq_datapath #(.NUM_CORES(NUM_CORES), .NUM_PINS(NUM_PINS), .ROUTE_CAPS(ROUTE_CAPS)) dp_i (
    .clk(clk), .rstN(rstN), .st(st), .evtStrobe(evtStrobe), .otherSelFlat(otherSelFlat),
    .rdCore(rdCore), .rdAddr(rdAddr), .rdData(rdData), .irqLines(irqLines), .irqVec(irqVec)
  );
endmodule

// File: tb/lirq_unit_tb.sv
module lirq_unit_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [3:0] wrCore = '0;
  logic [4:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic [3:0] rdCore = '0;
  logic [4:0] rdAddr = '0;
  logic [7:0] rdData;
  logic [8:0] evtStrobe = '0;
  logic [23:0] irqLines;
  logic [8:0] irqVec;
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  lirq_unit dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrCore(wrCore), .wrAddr(wrAddr), .wrData(wrData),
    .rdCore(rdCore), .rdAddr(rdAddr), .rdData(rdData), .evtStrobe(evtStrobe),
    .irqLines(irqLines), .irqVec(irqVec)
  );

  task automatic checkVal(input string tag, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, actual, expected);
    end
  endtask

  task automatic doWrite(input int core, input int addr, input int data, input logic [8:0] evt = '0);
    @(negedge clk);
    wrEn = 1'b1; wrCore = 4'(core); wrAddr = 5'(addr); wrData = 8'(data); evtStrobe = evt;
    @(negedge clk);
    wrEn = 1'b0; evtStrobe = '0;
  endtask

  task automatic pulse(input logic [8:0] evt);
    @(negedge clk); evtStrobe = evt;
    @(negedge clk); evtStrobe = '0;
  endtask

  task automatic expReg(input string tag, input int core, input int addr, input int expected);
    rdCore = 4'(core); rdAddr = 5'(addr);
    #1;
    checkVal(tag, int'(rdData), expected);
  endtask

  task automatic expOut(input string tag, input int lines0, input int vec0);
    #1;
    checkVal({tag, " lines"}, int'(irqLines[7:0]), lines0);
    checkVal({tag, " vec"}, int'(irqVec[2:0]), vec0);
  endtask

  task automatic t_reset();
    for (int c = 0; c < 3; c++) begin
      expReg("R1 mask", c, 1, 0);
      expReg("R1 pend", c, 4, 0);
      expReg("R1 osel", c, 6, 0);
      expReg("R1 map0", c, 16, 0);
      expReg("R6 ctrl reset", c, 0, 8'h0A);
    end
    checkVal("R1 lines", int'(irqLines), 0);
    checkVal("R1 vec", int'(irqVec), 0);
  endtask

  task automatic t_mask();
    doWrite(1, 2, 8'h13);
    expReg("R2 setmask", 1, 1, 8'h13);
    expReg("R7 core0 untouched", 0, 1, 0);
    doWrite(1, 3, 8'h01);
    expReg("R2 clrmask", 1, 1, 8'h12);
    doWrite(1, 3, 8'hFF);
    expReg("R2 clr all", 1, 1, 0);
    doWrite(2, 2, 8'h08);
    expReg("R7 core2 local", 2, 1, 8'h08);
    expReg("R7 core1 unchanged", 1, 1, 0);
    doWrite(2, 3, 8'hFF);
  endtask

  task automatic t_pend();
    pulse(9'b000_000_001);
    expReg("R3 timer strobe", 0, 4, 8'h01);
    expReg("R3 other core pend", 1, 4, 0);
    doWrite(0, 5, 8'h1F);
    expReg("R3 sw raise", 0, 4, 8'h19);
    doWrite(0, 4, 8'h09);
    expReg("R3 w1c", 0, 4, 8'h10);
    pulse(9'b000_000_010);
    // clear perf and soft1 in the same cycle as a new perf strobe: strobe wins
    doWrite(0, 4, 8'h12, 9'b000_000_010);
    expReg("R3 strobe beats clear", 0, 4, 8'h02);
  endtask

  task automatic t_route();
    doWrite(0, 4, 8'h1F);
    doWrite(0, 16, 8'h83);
    pulse(9'b000_000_001);
    expOut("R5 masked", 0, 0);
    doWrite(0, 2, 8'h01);
    expOut("R4 pin3", 8'h20, 4);
    doWrite(0, 16, 8'h03);
    expOut("R5 map disabled", 0, 0);
    doWrite(0, 16, 8'hFB);
    expReg("R4 map readback", 0, 16, 8'h83);
    doWrite(0, 17, 8'h81);
    doWrite(0, 2, 8'h02);
    pulse(9'b000_000_010);
    expOut("R5 not routable", 8'h20, 4);
    doWrite(0, 0, 8'h01);
    expOut("R6 vectored routes all", 8'h28, 2);
    expReg("R6 ctrl vectored", 0, 0, 8'h1F);
    doWrite(0, 18, 8'h87);
    doWrite(0, 2, 8'h04);
    pulse(9'b000_000_100);
    expOut("R10 pin out of range", 8'h28, 2);
    doWrite(0, 0, 8'h00);
    expOut("R6 vectored off", 8'h20, 4);
    expReg("R6 ctrl off", 0, 0, 8'h0A);
  endtask

  task automatic t_other();
    doWrite(0, 6, 2);
    expReg("R8 sel stored", 0, 6, 2);
    expReg("R8 sel per issuer", 1, 6, 0);
    doWrite(0, 7, 8'h04);
    expReg("R8 other setmask", 2, 1, 8'h04);
    expReg("R8 issuer mask kept", 0, 1, 8'h07);
    expReg("R8 omask read", 0, 9, 8'h04);
    doWrite(0, 24, 8'h85);
    expReg("R8 other map", 2, 16, 8'h85);
    expReg("R8 omap read", 0, 24, 8'h85);
    expReg("R8 issuer map kept", 0, 16, 8'h83);
    doWrite(0, 8, 8'hFF);
    expReg("R8 other clrmask", 2, 1, 0);
    doWrite(0, 6, 3);
    expReg("R9 bad sel ignored", 0, 6, 2);
    doWrite(1, 6, 9);
    expReg("R9 bad sel core1", 1, 6, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_mask();
    t_pend();
    t_route();
    t_other();
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule